// File: doc/BRIEF.md
# Oversampled Linear Retiming Phase Detector

This block is a cycle-accurate digital model of a linear phase detector for clock and data recovery. It is built from two retiming flops and two exclusive-OR gates. A fast oversampling clock drives every register. The serial data bit and the recovered-clock level arrive as levels, and they are sampled on that fast clock. A rising edge of the recovered clock is seen as a 0 to 1 change between two consecutive ticks, and a falling edge as a 1 to 0 change.

A selectable delay of whole ticks sits in the data path. It plays the role of the compensating delay that matches the retimer's clock-to-output time. After this delay, the data is retimed on each rising edge of the recovered clock. That retimed bit is then retimed again on each falling edge. The first exclusive-OR gives a proportional pulse, whose width follows the phase error. The second gives a reference pulse, which is half a bit wide for every data transition. Because the reference comes from the falling-edge retimer, the offset that transition density would cause is removed, and only the gain depends on density.

Both pulses are registered each tick. A windowed signed counter adds one for each proportional tick and subtracts one for each reference tick. At each window end it reports the total, and the total saturates at its signed limits. A loop filter or a lock monitor can use this count as a digital phase-error figure.

Top module: `hogge_pd_os`

## Requirements
- R1: While `rst` is high and on the first tick after it, `up`, `dn`, `err_vld` and `err_cnt` are all zero. Reset clears both retimers and the accumulator.
- R2: The data seen by the detector is `din` delayed by `comp_dly` + 1 ticks. A recovered-clock rise is `rck` equal to 1 on one tick after 0 on the tick before. On a rise, the first retimer loads the delayed data. `up` is the registered XOR of the delayed data and the first retimer, and it is one tick late.
- R3: On a recovered-clock fall (`rck` 1 then 0), the second retimer loads the first retimer. `dn` is the registered XOR of the two retimers, and it is also one tick late. The second retimer changes on no other tick.
- R4: With a 50% duty recovered clock of OSR ticks per period, each data transition gives a `dn` pulse of exactly OSR/2 ticks. A bit with no transition gives no `up` tick and no `dn` tick.
- R5: In lock, a data transition falls on a recovered-clock fall. With `comp_dly` = 1, the window sum is then zero for both alternating data and two-bit runs. With `comp_dly` = 0, the sum is +1 for each transition.
- R6: Each extra tick of `comp_dly` makes the proportional pulse one tick shorter per transition. Values above MAX_DLY act as MAX_DLY.
- R7: Every OSR*WIN_BITS ticks, `err_vld` is high for exactly one tick. On that tick `err_cnt` holds (up ticks) minus (dn ticks) for the window just ended, and the accumulator restarts from zero.
- R8: The accumulator and `err_cnt` saturate at +(2^(CNT_W-1))-1 and -(2^(CNT_W-1)). They never wrap.
- R9: When the recovered clock lags lock by k ticks, the window sum rises by k for each transition. When it leads by k ticks, the sum falls by k for each transition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock |
| rst | input | 1 | Synchronous active-high reset |
| din | input | 1 | Serial data level, sampled each tick |
| rck | input | 1 | Recovered-clock level, sampled each tick |
| comp_dly | input | $clog2(MAX_DLY+1) | Compensating data delay in ticks |
| up | output | 1 | Registered proportional pulse |
| dn | output | 1 | Registered reference pulse |
| err_cnt | output | CNT_W (signed) | Phase-error sum of the last window |
| err_vld | output | 1 | One-tick strobe, high when err_cnt is new |

## Verification
The bench builds the block with OSR = 8, WIN_BITS = 8 (a 64-tick window), MAX_DLY = 3 and CNT_W = 6. With these values, half a bit is four ticks, so a phase shift of one or two ticks gives an exact window sum that can be read directly. Every delay tap can be selected. A stuck detector drives the counter past its ±31/−32 limits within one window, so saturation in both directions can be reached in a few hundred cycles. The window is a whole number of bit periods, so periodic patterns give sums that do not depend on where the window falls.

// File: rtl/hpd_pkg.sv
package hpd_pkg;

  typedef enum logic [1:0] {
    STEP_NONE = 2'd0,
    STEP_UP   = 2'd1,
    STEP_DN   = 2'd2
  } step_e;

  function automatic step_e step_of(input logic up_c, input logic dn_c);
    if (up_c && !dn_c)      return STEP_UP;
    else if (dn_c && !up_c) return STEP_DN;
    else                    return STEP_NONE;
  endfunction

endpackage

// File: rtl/hpd_tap_delay.sv
module hpd_tap_delay #(
  parameter int MAX_DLY = 7,
  localparam int SEL_W  = $clog2(MAX_DLY + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             d_in,
  input  logic [SEL_W-1:0] sel,
  output logic             d_out
);

  logic [MAX_DLY:0] stage;

  always_ff @(posedge clk) begin
    if (rst) stage <= '0;
    else     stage <= {stage[MAX_DLY-1:0], d_in};
  end

  generate
    if ((1 << SEL_W) == MAX_DLY + 1) begin : g_full
      assign d_out = stage[sel];
    end else begin : g_clamp
      assign d_out = (sel > SEL_W'(MAX_DLY)) ? stage[MAX_DLY] : stage[sel];
    end
  endgenerate

endmodule

// File: rtl/hpd_retimer.sv
module hpd_retimer (
  input  logic clk,
  input  logic rst,
  input  logic dat,
  input  logic rck_lvl,
  output logic up_c,
  output logic dn_c,
  output logic q,
  output logic qr
);

  logic rck_now, rck_prev;
  logic rise, fall;

  always_ff @(posedge clk) begin
    if (rst) begin
      rck_now  <= 1'b0;
      rck_prev <= 1'b0;
    end else begin
      rck_now  <= rck_lvl;
      rck_prev <= rck_now;
    end
  end

  assign rise = rck_now & ~rck_prev;
  assign fall = ~rck_now & rck_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      q  <= 1'b0;
      qr <= 1'b0;
    end else begin
      if (rise) q  <= dat;
      if (fall) qr <= q;
    end
  end

  assign up_c = dat ^ q;
  assign dn_c = q ^ qr;

endmodule

// File: rtl/hpd_err_window.sv
module hpd_err_window
  import hpd_pkg::*;
#(
  parameter int WIN   = 512,
  parameter int CNT_W = 12
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    up_c,
  input  logic                    dn_c,
  output logic signed [CNT_W-1:0] err_cnt,
  output logic                    err_vld,
  output logic signed [CNT_W-1:0] acc_o
);

  localparam int WCNT_W = (WIN > 1) ? $clog2(WIN) : 1;
  localparam logic signed [CNT_W-1:0] CMAX = {1'b0, {(CNT_W-1){1'b1}}};
  localparam logic signed [CNT_W-1:0] CMIN = {1'b1, {(CNT_W-1){1'b0}}};
  localparam logic signed [CNT_W-1:0] ONE  = CNT_W'(1);

  logic [WCNT_W-1:0]        wcnt;
  logic                     wrap;
  logic signed [CNT_W-1:0]  acc, nxt;
  step_e                    st;

  assign wrap = (wcnt == WCNT_W'(WIN - 1));
  assign st   = step_of(up_c, dn_c);

  always_comb begin
    case (st)
      STEP_UP: nxt = (acc == CMAX) ? acc : acc + ONE;
      STEP_DN: nxt = (acc == CMIN) ? acc : acc - ONE;
      default: nxt = acc;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wcnt    <= '0;
      acc     <= '0;
      err_cnt <= '0;
      err_vld <= 1'b0;
    end else begin
      err_vld <= wrap;
      if (wrap) begin
        err_cnt <= nxt;
        acc     <= '0;
        wcnt    <= '0;
      end else begin
        acc     <= nxt;
        wcnt    <= wcnt + WCNT_W'(1);
      end
    end
  end

  assign acc_o = acc;

endmodule

// File: rtl/hogge_pd_os.sv
module hogge_pd_os #(
  parameter int OSR      = 16,
  parameter int WIN_BITS = 32,
  parameter int MAX_DLY  = 7,
  parameter int CNT_W    = 12
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              din,
  input  logic                              rck,
  input  logic [$clog2(MAX_DLY+1)-1:0]      comp_dly,
  output logic                              up,
  output logic                              dn,
  output logic signed [CNT_W-1:0]           err_cnt,
  output logic                              err_vld
);

  localparam int WIN = OSR * WIN_BITS;

  logic                    dat_dly;
  logic                    up_c, dn_c;
  logic                    q_w, qr_w;
  logic signed [CNT_W-1:0] acc_w;

  hpd_tap_delay #(.MAX_DLY(MAX_DLY)) u_dly (
    .clk   (clk),
    .rst   (rst),
    .d_in  (din),
    .sel   (comp_dly),
    .d_out (dat_dly)
  );

  hpd_retimer u_rt (
    .clk     (clk),
    .rst     (rst),
    .dat     (dat_dly),
    .rck_lvl (rck),
    .up_c    (up_c),
    .dn_c    (dn_c),
    .q       (q_w),
    .qr      (qr_w)
  );

  hpd_err_window #(.WIN(WIN), .CNT_W(CNT_W)) u_win (
    .clk     (clk),
    .rst     (rst),
    .up_c    (up_c),
    .dn_c    (dn_c),
    .err_cnt (err_cnt),
    .err_vld (err_vld),
    .acc_o   (acc_w)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      up <= 1'b0;
      dn <= 1'b0;
    end else begin
      up <= up_c;
      dn <= dn_c;
    end
  end

endmodule

// File: rtl/hpd_checker.sv
module hpd_checker #(
  parameter int CNT_W = 12
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    rck,
  input logic                    up,
  input logic                    dn,
  input logic                    err_vld,
  input logic                    q,
  input logic                    qr,
  input logic signed [CNT_W-1:0] acc
);

  localparam logic signed [CNT_W-1:0] CMAX = {1'b0, {(CNT_W-1){1'b1}}};
  localparam logic signed [CNT_W-1:0] CMIN = {1'b1, {(CNT_W-1){1'b0}}};
  localparam logic signed [CNT_W-1:0] ONE  = CNT_W'(1);

  logic r1, r2;
  always_ff @(posedge clk) begin
    if (rst) begin
      r1 <= 1'b0;
      r2 <= 1'b0;
    end else begin
      r1 <= rck;
      r2 <= r1;
    end
  end

  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (!up && !dn && !err_vld));

  assert_q_on_rise_R2: assert property (@(posedge clk) disable iff (rst)
    (q != $past(q)) |-> $past(r1 && !r2));

  assert_qr_on_fall_R3: assert property (@(posedge clk) disable iff (rst)
    (qr != $past(qr)) |-> $past(!r1 && r2));

  assert_single_strobe_R7: assert property (@(posedge clk) disable iff (rst)
    err_vld |=> !err_vld);

  assert_no_wrap_high_R8: assert property (@(posedge clk) disable iff (rst)
    (acc == CMAX) |=> (acc == CMAX || acc == CMAX - ONE || acc == '0));

  assert_no_wrap_low_R8: assert property (@(posedge clk) disable iff (rst)
    (acc == CMIN) |=> (acc == CMIN || acc == CMIN + ONE || acc == '0));

endmodule

bind hogge_pd_os hpd_checker #(.CNT_W(CNT_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .rck     (rck),
  .up      (up),
  .dn      (dn),
  .err_vld (err_vld),
  .q       (q_w),
  .qr      (qr_w),
  .acc     (acc_w)
);

// File: tb/sim_hogge_pd_os.sv
module sim_hogge_pd_os;

  localparam int OSR = 8;
  localparam int WB  = 8;
  localparam int MD  = 3;
  localparam int CW  = 6;
  localparam int WIN = OSR * WB;
  localparam int SMAX = (1 << (CW - 1)) - 1;
  localparam int SMIN = -(1 << (CW - 1));

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic din = 1'b0;
  logic rck = 1'b0;
  logic [1:0] comp_dly = 2'd0;
  logic up, dn, err_vld;
  logic signed [CW-1:0] err_cnt;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  hogge_pd_os #(.OSR(OSR), .WIN_BITS(WB), .MAX_DLY(MD), .CNT_W(CW)) u0 (
    .clk(clk), .rst(rst), .din(din), .rck(rck), .comp_dly(comp_dly),
    .up(up), .dn(dn), .err_cnt(err_cnt), .err_vld(err_vld)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // stimulus generator
  int pat_mode = 0;   // 0 alt, 1 two-bit runs, 2 pseudo-random, 3 constant
  int ph = 0;         // positive: recovered clock lags
  int rck_held = 0;
  int rck_hold_val = 0;
  int din_const = 0;
  int g = 0;

  function automatic int pat_bit(input int m, input int b);
    logic [31:0] h;
    h = 32'(b) * 32'h9E3779B1;
    case (m)
      0: return b & 1;
      1: return (b >> 1) & 1;
      2: return int'(h[17]);
      default: return din_const;
    endcase
  endfunction

  always @(negedge clk) begin
    g = g + 1;
    din <= pat_bit(pat_mode, g / OSR) != 0;
    if (rck_held != 0) rck <= (rck_hold_val != 0);
    else               rck <= ((((g - ph) % OSR) + OSR) % OSR) >= OSR / 2;
  end

  // behavioural reference model
  int dq[$];
  int rq[$];
  int mq = 0, mqr = 0, macc = 0, mwc = 0;
  int m_up = 0, m_dn = 0, m_err = 0, m_vld = 0;

  always @(posedge clk) begin
    if (rst) begin
      dq.delete(); rq.delete();
      mq = 0; mqr = 0; macc = 0; mwc = 0;
      m_up = 0; m_dn = 0; m_err = 0; m_vld = 0;
    end else begin
      int dly, dd, rs, rp, nu, nd, a;
      dly = (int'(comp_dly) > MD) ? MD : int'(comp_dly);
      dd = (dq.size() > dly) ? dq[dq.size() - 1 - dly] : 0;
      rs = (rq.size() >= 1) ? rq[rq.size() - 1] : 0;
      rp = (rq.size() >= 2) ? rq[rq.size() - 2] : 0;
      nu = dd ^ mq;
      nd = mq ^ mqr;
      a = macc + nu - nd;
      if (a > SMAX) a = SMAX;
      if (a < SMIN) a = SMIN;
      if (mwc == WIN - 1) begin
        m_err = a; m_vld = 1; macc = 0; mwc = 0;
      end else begin
        m_vld = 0; macc = a; mwc = mwc + 1;
      end
      if (!(rs != 0) && (rp != 0)) mqr = mq;
      if ((rs != 0) && !(rp != 0)) mq = dd;
      m_up = nu; m_dn = nd;
      dq.push_back(int'(din));
      rq.push_back(int'(rck));
      if (dq.size() > 8) void'(dq.pop_front());
      if (rq.size() > 8) void'(rq.pop_front());
    end
  end

  bit cmp_on = 1'b0;
  always @(negedge clk) begin
    if (cmp_on && !rst) begin
      chk(up == (m_up != 0), "R2 up vs model", int'(up), m_up);
      chk(dn == (m_dn != 0), "R3 dn vs model", int'(dn), m_dn);
      chk(err_vld == (m_vld != 0), "R7 strobe vs model", int'(err_vld), m_vld);
      if (m_vld != 0) chk(int'(err_cnt) == m_err, "R7 window sum vs model", int'(err_cnt), m_err);
    end
  end

  task automatic read_window(output int v);
    do @(negedge clk); while (!err_vld);
    v = int'(err_cnt);
  endtask

  task automatic settle_read(input int exp, input string tag);
    int v;
    repeat (3 * WIN) @(negedge clk);
    read_window(v);
    chk(v == exp, tag, v, exp);
  endtask

  task automatic count_pulses(output int nu, output int nd);
    nu = 0; nd = 0;
    for (int i = 0; i < WIN; i++) begin
      @(negedge clk);
      nu += int'(up);
      nd += int'(dn);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL R7 watchdog actual=%0d expected=%0d", 0, 1);
    finish_run();
  end

  initial begin
    int nu, nd, t0, t1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(!up && !dn, "R1 pulses quiet in reset", int'(up) + int'(dn), 0);
    chk(!err_vld && err_cnt == 0, "R1 counter clear in reset", int'(err_cnt), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!up && !dn && !err_vld, "R1 quiet after release", int'(up) + int'(dn) + int'(err_vld), 0);
    cmp_on = 1'b1;

    // R5 lock, alternating data, compensated
    pat_mode = 0; ph = 0; comp_dly = 2'd1;
    settle_read(0, "R5 locked alternating comp=1");
    // R5 uncompensated: +1 per transition, 8 transitions
    comp_dly = 2'd0;
    settle_read(8, "R5 locked alternating comp=0");
    // R5 two-bit runs, density halved, still zero
    pat_mode = 1; comp_dly = 2'd1;
    settle_read(0, "R5 locked two-bit runs comp=1");
    // R4 pulse widths: 4 transitions x 4 ticks each
    count_pulses(nu, nd);
    chk(nd == 16, "R4 dn ticks per window", nd, 16);
    chk(nu == 16, "R4 up ticks per window", nu, 16);
    // R9 late and early clock
    pat_mode = 0; ph = 2;
    settle_read(16, "R9 clock late by 2");
    ph = -2;
    settle_read(-16, "R9 clock early by 2");
    // R6 larger delay tap
    ph = 0; comp_dly = 2'd3;
    settle_read(-16, "R6 comp=3 shortens up");
    // R7 window period
    read_window(nu); t0 = g;
    read_window(nu); t1 = g;
    chk(t1 - t0 == WIN, "R7 strobe period", t1 - t0, WIN);
    // R4 no transitions -> no pulses
    pat_mode = 3; din_const = 0; comp_dly = 2'd1;
    repeat (2 * WIN) @(negedge clk);
    count_pulses(nu, nd);
    chk(nu == 0 && nd == 0, "R4 constant data no pulses", nu + nd, 0);
    // random data, model comparison only (R2, R3)
    pat_mode = 2; ph = 1; comp_dly = 2'd2;
    repeat (6 * WIN) @(negedge clk);
    // R8 saturation high then low
    pat_mode = 3; din_const = 0; ph = 0;
    repeat (2 * WIN) @(negedge clk);
    rck_hold_val = 0; rck_held = 1;
    repeat (4) @(negedge clk);
    din_const = 1;
    settle_read(SMAX, "R8 saturate high");
    rck_hold_val = 1;
    settle_read(SMIN, "R8 saturate low");
    repeat (4) @(negedge clk);
    finish_run();
  end

endmodule